// File: doc/BRIEF.md
# Burst-Absorbing Circular FIFO

This block is a single-clock first-in first-out buffer. It stores data in an array of registers that is addressed by a write index and a read index, and each index is exactly log2(DEPTH) bits wide. Occupancy comes from subtracting one index from the other, and the subtraction wraps by itself. When the difference is zero the buffer could be either empty or full, so the block resolves this with one bit that records which side moved last. The block reports the count together with empty, full, almost-empty and almost-full flags. It also exports a hold signal that tells an upstream producer to pause.

The read side can run in one of two modes. In manual mode the consumer requests reads itself. In auto mode a small drain controller waits until a burst has built up to a prefill level. It then reads on every cycle until the buffer is empty, which gives a continuous output stream from bursty input.

Top module: `sfifo_burst`

## Requirements
- R1: While reset is high and on the cycle after it is released, the outputs read as follows: count is 0, empty is 1, full is 0, almost_empty is 1, almost_full is 0, hold_producer is 0 and rd_valid is 0.
- R2: Data leaves the buffer in the order it was accepted. After an accepted read, rd_data holds the word and rd_valid is 1 on the next cycle. rd_valid is 0 after any cycle with no accepted read.
- R3: count is (write index - read index) taken modulo DEPTH, and it shows DEPTH when the buffer is full. It is log2(DEPTH)+1 bits wide. With DEPTH=8, the state after 3 writes, then 3 reads, then 6 writes gives a count of 6.
- R4: A zero index difference means full when the last single-sided change was a write, and empty when it was a read. full and empty are never 1 at the same time.
- R5: A write while full is dropped. The count stays at DEPTH and no stored word is overwritten.
- R6: A read while empty is dropped. The count stays at 0 and rd_valid stays 0.
- R7: A read and a write in the same cycle leave the count unchanged when the buffer is neither empty nor full. When full, only the read is accepted. When empty, only the write is accepted.
- R8: almost_empty is count <= AE and almost_full is count >= AF. Both flags change in the same cycle as count.
- R9: hold_producer equals almost_full.
- R10: With auto_drain=1, no read is issued while the controller is idle. The controller leaves idle on the cycle after count reaches PREFILL. It then reads on every cycle while the buffer is not empty, and it goes back to idle once the buffer is empty.
- R11: With auto_drain=1 the rd_req input has no effect. With auto_drain=0 reads follow rd_req alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Word to store |
| auto_drain | input | 1 | 1 selects the drain controller, 0 selects rd_req |
| rd_req | input | 1 | Manual read request |
| rd_data | output | W | Registered read word |
| rd_valid | output | 1 | rd_data carries a word read in the previous cycle |
| count | output | log2(DEPTH)+1 | Occupancy |
| empty | output | 1 | No words held |
| full | output | 1 | DEPTH words held |
| almost_empty | output | 1 | count <= AE |
| almost_full | output | 1 | count >= AF |
| hold_producer | output | 1 | Stall to upstream producer |

## Verification
Directed sequences come first. One fills the buffer to full and keeps writing, another reads an empty buffer, and a third wraps the write index past the read index. Together these separate the zero-difference full case from the zero-difference empty case and confirm the modular count. Requests that collide on a full, an empty and a partly filled buffer show which side wins in each state. Long mixed streams at several write densities exercise every occupancy and flag threshold, and they catch ordering errors. Auto-mode bursts, with a random rd_req applied, show that the prefill hold-off and continuous draining work and that rd_req is ignored in this mode.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic {
        DRAIN_IDLE = 1'b0,
        DRAIN_RUN  = 1'b1
    } drain_state_t;

    typedef struct packed {
        logic empty;
        logic full;
        logic almost_empty;
        logic almost_full;
    } occ_flags_t;

    function automatic bit is_pow2(input int unsigned v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_fire,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_fire,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid
);

    logic [W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (wr_fire && (wr_addr == AW'(i)))
                cell_q <= wr_data;
        end
        assign cells[i] = cell_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire)
                rd_data <= cells[rd_addr];
        end
    end

    // R2
    read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> rd_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_fire |=> !rd_valid);

endmodule

// File: rtl/sfifo_ptrs.sv
module sfifo_ptrs
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AE    = 2,
    parameter int AF    = 6,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_fire,
    output logic          rd_fire,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output occ_flags_t    flags
);

    logic [AW-1:0] wp_q, rp_q, wp_n, rp_n, diff, diff_n;
    logic          dir_q, dir_n;
    logic          full_c, empty_c;
    logic [CW-1:0] cnt_n;
    logic          ae_q, af_q;

    assign diff    = wp_q - rp_q;
    assign full_c  = (diff == '0) && dir_q;
    assign empty_c = (diff == '0) && !dir_q;

    assign wr_fire = wr_req && !full_c;
    assign rd_fire = rd_req && !empty_c;

    always_comb begin
        wp_n  = wp_q + AW'(wr_fire);
        rp_n  = rp_q + AW'(rd_fire);
        dir_n = dir_q;
        if (wr_fire && !rd_fire) dir_n = 1'b1;
        if (rd_fire && !wr_fire) dir_n = 1'b0;
        diff_n = wp_n - rp_n;
        cnt_n  = ((diff_n == '0) && dir_n) ? CW'(DEPTH) : {1'b0, diff_n};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            dir_q <= 1'b0;
            ae_q  <= 1'b1;
            af_q  <= 1'b0;
        end else begin
            wp_q  <= wp_n;
            rp_q  <= rp_n;
            dir_q <= dir_n;
            ae_q  <= (cnt_n <= CW'(AE));
            af_q  <= (cnt_n >= CW'(AF));
        end
    end

    assign wr_ptr = wp_q;
    assign rd_ptr = rp_q;
    assign count  = full_c ? CW'(DEPTH) : {1'b0, diff};

    assign flags.empty        = empty_c;
    assign flags.full         = full_c;
    assign flags.almost_empty = ae_q;
    assign flags.almost_full  = af_q;

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R4
    fills_to_full_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !rd_req && count == CW'(DEPTH - 1)) |=> flags.full);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.full && wr_req && !rd_req) |=> ($stable(wp_q) && flags.full));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && rd_req && !wr_req) |=> ($stable(rp_q) && flags.empty));

    // R7
    balanced_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (!flags.full && !flags.empty && wr_req && rd_req) |=> $stable(count));

    // R8
    ae_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        ae_q == (count <= CW'(AE)));

    // R8
    af_thresh_chk: assert property (@(posedge clk) disable iff (rst)
        af_q == (count >= CW'(AF)));

endmodule

// File: rtl/sfifo_drain.sv
module sfifo_drain
    import sfifo_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int PREFILL = 4,
    localparam int CW     = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count_i,
    input  logic          empty_i,
    output logic          rd_auto
);

    drain_state_t st_q, st_n;

    always_comb begin
        st_n = st_q;
        case (st_q)
            DRAIN_IDLE: if (count_i >= CW'(PREFILL)) st_n = DRAIN_RUN;
            DRAIN_RUN:  if (empty_i)                 st_n = DRAIN_IDLE;
            default:                                 st_n = DRAIN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= DRAIN_IDLE;
        else     st_q <= st_n;
    end

    assign rd_auto = (st_q == DRAIN_RUN) && !empty_i;

    // R10
    prefill_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == DRAIN_RUN) |-> ($past(count_i) >= CW'(PREFILL)));

    // R10
    idle_after_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == DRAIN_RUN && empty_i) |=> (st_q == DRAIN_IDLE));

endmodule

// File: rtl/sfifo_burst.sv
module sfifo_burst
    import sfifo_pkg::*;
#(
    parameter int W       = 8,
    parameter int DEPTH   = 8,
    parameter int AE      = 2,
    parameter int AF      = 6,
    parameter int PREFILL = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          auto_drain,
    input  logic          rd_req,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full,
    output logic          hold_producer
);

    initial begin
        if (!is_pow2(DEPTH)) $error("DEPTH must be a power of two");
    end

    logic          wr_fire, rd_fire, rd_auto, rd_sel;
    logic [AW-1:0] wr_ptr, rd_ptr;
    occ_flags_t    flags;

    assign rd_sel = auto_drain ? rd_auto : rd_req;

    sfifo_ptrs #(.DEPTH(DEPTH), .AE(AE), .AF(AF)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_en),
        .rd_req  (rd_sel),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (count),
        .flags   (flags)
    );

    sfifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_fire  (wr_fire),
        .wr_addr  (wr_ptr),
        .wr_data  (wr_data),
        .rd_fire  (rd_fire),
        .rd_addr  (rd_ptr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    sfifo_drain #(.DEPTH(DEPTH), .PREFILL(PREFILL)) u_drain (
        .clk     (clk),
        .rst     (rst),
        .count_i (count),
        .empty_i (flags.empty),
        .rd_auto (rd_auto)
    );

    assign empty         = flags.empty;
    assign full          = flags.full;
    assign almost_empty  = flags.almost_empty;
    assign almost_full   = flags.almost_full;
    assign hold_producer = flags.almost_full;

    // R11
    manual_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!auto_drain && !rd_req) |=> !rd_valid);

endmodule

// File: tb/tb_sfifo_burst.sv
`timescale 1ns/1ps
module tb_sfifo_burst;

    localparam int W = 8, DEPTH = 8, AE = 2, AF = 6, PREFILL = 4;
    localparam int CW = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          auto_drain = 1'b0;
    logic          rd_req = 1'b0;
    logic [W-1:0]  rd_data;
    logic          rd_valid;
    logic [CW-1:0] count;
    logic          empty, full, almost_empty, almost_full, hold_producer;

    sfifo_burst #(.W(W), .DEPTH(DEPTH), .AE(AE), .AF(AF), .PREFILL(PREFILL)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .auto_drain(auto_drain), .rd_req(rd_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .count(count), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full),
        .hold_producer(hold_producer)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int q[$];
    bit m_run = 1'b0;
    bit e_valid = 1'b0;
    int e_data = 0;
    int seq = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL [%s] actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int n = q.size();
        chk({tag, " R3 count"}, int'(count), n);
        chk({tag, " R4 empty"}, int'(empty), int'(n == 0));
        chk({tag, " R4 full"}, int'(full), int'(n == DEPTH));
        chk({tag, " R8 almost_empty"}, int'(almost_empty), int'(n <= AE));
        chk({tag, " R8 almost_full"}, int'(almost_full), int'(n >= AF));
        chk({tag, " R9 hold_producer"}, int'(hold_producer), int'(n >= AF));
        chk({tag, " R2 rd_valid"}, int'(rd_valid), int'(e_valid));
        if (e_valid) chk({tag, " R2 rd_data"}, int'(rd_data), e_data);
    endtask

    // Drive one cycle at the falling edge, advance the model, check at the next falling edge.
    task automatic step(bit w, bit r, bit am, string tag);
        int  n     = q.size();
        bit  mempt = (n == 0);
        bit  rd    = am ? (m_run && !mempt) : r;
        bit  wa    = w && (n != DEPTH);
        bit  ra    = rd && !mempt;
        wr_en      = w;
        wr_data    = W'(seq);
        rd_req     = r;
        auto_drain = am;
        e_valid    = ra;
        if (ra) e_data = q.pop_front();
        if (wa) q.push_back(seq & 8'hFF);
        seq++;
        if (!m_run && n >= PREFILL) m_run = 1'b1;
        else if (m_run && mempt)    m_run = 1'b0;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL [watchdog] actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check_all("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset");

        // R5: fill, then keep writing while full
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, "R4 fill");
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R5 write while full");
        // R2: drain shows original order, nothing overwritten
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "R2 R5 drain");
        // R6: read while empty
        for (int i = 0; i < 3; i++) step(0, 1, 0, "R6 read while empty");

        // R3: wrap example 3 writes, 3 reads, 6 writes -> 6
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R3 wrap");
        for (int i = 0; i < 3; i++) step(0, 1, 0, "R3 wrap");
        for (int i = 0; i < 6; i++) step(1, 0, 0, "R3 wrap");
        chk("R3 wrapped count is 6", int'(count), 6);

        // R7: simultaneous on partial, full, empty
        for (int i = 0; i < 4; i++) step(1, 1, 0, "R7 both partial");
        for (int i = 0; i < 2; i++) step(1, 0, 0, "R7 to full");
        step(1, 1, 0, "R7 both on full");
        chk("R7 full collision drops write", int'(count), DEPTH - 1);
        while (q.size() != 0) step(0, 1, 0, "R7 drain");
        step(1, 1, 0, "R7 both on empty");
        chk("R7 empty collision drops read", int'(count), 1);
        step(0, 1, 0, "R7 drain");

        // Mixed manual sweeps at several write densities
        for (int d = 1; d <= 7; d += 2) begin
            for (int i = 0; i < 1500; i++) begin
                bit w = ($urandom_range(7) < d);
                bit r = ($urandom_range(7) < 4);
                step(w, r, 0, "R2 R3 R8 manual sweep");
            end
        end
        while (q.size() != 0) step(0, 1, 0, "drain");

        // R10: below prefill nothing is read in auto mode
        for (int i = 0; i < PREFILL - 1; i++) step(1, 1, 1, "R10 R11 below prefill");
        for (int i = 0; i < 5; i++) step(0, 1, 1, "R10 hold off");
        chk("R10 no read below prefill", int'(count), PREFILL - 1);

        // R10 R11: bursty producer honouring hold_producer, random rd_req ignored
        for (int i = 0; i < 4000; i++) begin
            bit burst = ((i / 12) % 3) != 2;
            bit w = burst && !hold_producer;
            step(w, bit'($urandom_range(1)), 1, "R10 R11 auto burst");
        end
        for (int i = 0; i < 2 * DEPTH; i++) step(0, 0, 1, "R10 auto drain");
        chk("R10 auto drained to empty", int'(empty), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule